// File: doc/BRIEF.md
# Exception PC Chain Unit

This unit keeps the program counters that a five-stage processor needs to resume execution after an interrupt. The stages are IF, RF, ALU, MEM and WB, in that order. A three-entry shift chain follows the fetch address as the pipeline advances. At any moment, entry 0 holds the PC of the instruction in ALU, entry 1 the one in RF, and entry 2 the one in IF. The instructions in MEM and WB are left to finish on their own, so they need no slot.

When an interrupt is taken, the chain freezes and a status-word exception flag is raised. The chain then stays frozen for as long as the flag is set, so a second interrupt cannot disturb the saved addresses. The return path issues one state-restoring jump and then two plain chain jumps. Each jump pops the oldest saved PC onto the redirect output. The restoring jump also drops the exception flag. The chain starts following the fetch address again only after the last saved PC has been consumed. Interrupts that arrive while the chain is frozen or still being replayed are ignored; the interrupt source is expected to hold its request.

Top module: `pcc_unit`

## Requirements
- R1: Reset clears the exception flag, the redirect valid output and all chain entries. An interrupt taken straight after reset, with no advance, replays PC value 0 three times.
- R2: While the chain is live (exception flag clear and no saved PC left to replay), each cycle with `pipe_adv` high shifts the chain. `fetch_pc` enters entry 2 and the old entry 0 is dropped. Replay order is entry 0 first, then entry 1, then entry 2.
- R3: An interrupt request on a live chain sets the exception flag at the next clock edge. From then on the chain is frozen and `pipe_adv` has no effect on it.
- R4: An interrupt request while the exception flag is set is ignored. The flag stays set and the saved PCs are unchanged.
- R5: A restore-jump strobe while the exception flag is set does three things at the next edge: it drives the oldest saved PC on `redir_pc`, raises `redir_vld` for exactly one cycle, and clears the exception flag.
- R6: After the restore jump, each chain-jump strobe redirects to the next saved PC in order, until all three saved PCs have been delivered.
- R7: An interrupt request that arrives after the restore jump but before the last chain jump is ignored. The exception flag stays clear and the remaining replay delivers the saved PCs unchanged.
- R8: A restore-jump strobe while the exception flag is clear, or a chain-jump strobe while no saved PC remains, produces no redirect and leaves the chain unchanged.
- R9: Once the last saved PC has been consumed, `pipe_adv` shifts the chain again, and a later interrupt saves the newly shifted PCs. This includes a PC with every bit set.
- R10: If an interrupt request and `pipe_adv` arrive in the same cycle on a live chain, the interrupt wins and the chain does not shift.
- R11: `pipe_adv` during a replay (after the restore jump and before the last chain jump) does not shift the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | PC of the instruction entering IF |
| pipe_adv | input | 1 | Pipeline advances this cycle |
| irq_req | input | 1 | Interrupt request |
| jmp_restore | input | 1 | State-restoring return jump issued |
| jmp_chain | input | 1 | Plain chain jump issued |
| redir_pc | output | PC_W | Restart address for fetch |
| redir_vld | output | 1 | Restart address valid, one cycle per jump |
| exc_flag | output | 1 | Status-word exception bit |

## Verification
The bench builds the unit with a 16-bit PC and a chain depth of three. Three slots match the three restart addresses of the return sequence, and the narrow PC keeps the values readable while an all-ones address still shows that every bit is carried. With these values, every stage of the return sequence can be reached in a few cycles: the frozen state, each point between the three jumps, and the return to a live chain. A nested interrupt and a pipeline advance are injected at each of those points.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    // Action applied to the saved-PC chain in one cycle
    typedef enum logic [1:0] {
        CH_HOLD  = 2'd0,   // keep all entries
        CH_SHIFT = 2'd1,   // move toward entry 0, new fetch PC into the top
        CH_POP   = 2'd2    // move toward entry 0, top entry cleared
    } chain_op_e;

endpackage

// File: rtl/pcc_chain.sv
module pcc_chain
    import pcc_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int DEPTH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  chain_op_e                   op,
    input  logic [PC_W-1:0]             fill_pc,
    output logic [PC_W-1:0]             head_pc,
    output logic [DEPTH-1:0][PC_W-1:0]  entries
);

    localparam int TOP = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] ent;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op != CH_HOLD) begin
            for (int i = 0; i < TOP; i++) begin
                st_d.ent[i] = st_q.ent[i+1];
            end
            st_d.ent[TOP] = (op == CH_SHIFT) ? fill_pc : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_pc = st_q.ent[0];
    assign entries = st_q.ent;

endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
    import pcc_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pipe_adv,
    input  logic             irq_req,
    input  logic             jmp_restore,
    input  logic             jmp_chain,
    output chain_op_e        op,
    output logic             pop_fire,
    output logic             exc_flag,
    output logic [CNT_W-1:0] pend
);

    typedef struct packed {
        logic             exc;
        logic [CNT_W-1:0] pend;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        op       = CH_HOLD;
        pop_fire = 1'b0;
        if (st_q.exc) begin
            // frozen: only the restoring jump can act
            if (jmp_restore) begin
                op       = CH_POP;
                pop_fire = 1'b1;
                st_d.exc = 1'b0;
                st_d.pend = CNT_W'(DEPTH - 1);
            end
        end else if (st_q.pend != '0) begin
            // replay in progress: chain jumps drain, everything else waits
            if (jmp_chain) begin
                op        = CH_POP;
                pop_fire  = 1'b1;
                st_d.pend = st_q.pend - 1'b1;
            end
        end else begin
            // live chain: interrupt outranks advance
            if (irq_req) begin
                st_d.exc = 1'b1;
            end else if (pipe_adv) begin
                op = CH_SHIFT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_flag = st_q.exc;
    assign pend     = st_q.pend;

endmodule

// File: rtl/pcc_unit.sv
module pcc_unit
    import pcc_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int DEPTH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            pipe_adv,
    input  logic            irq_req,
    input  logic            jmp_restore,
    input  logic            jmp_chain,
    output logic [PC_W-1:0] redir_pc,
    output logic            redir_vld,
    output logic            exc_flag
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    chain_op_e                  op;
    logic                       pop_fire;
    logic [CNT_W-1:0]           pend;
    logic [PC_W-1:0]            head_pc;
    logic [DEPTH-1:0][PC_W-1:0] entries;

    pcc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_adv   (pipe_adv),
        .irq_req    (irq_req),
        .jmp_restore(jmp_restore),
        .jmp_chain  (jmp_chain),
        .op         (op),
        .pop_fire   (pop_fire),
        .exc_flag   (exc_flag),
        .pend       (pend)
    );

    pcc_chain #(.PC_W(PC_W), .DEPTH(DEPTH)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .fill_pc (fetch_pc),
        .head_pc (head_pc),
        .entries (entries)
    );

    typedef struct packed {
        logic            vld;
        logic [PC_W-1:0] pc;
    } redir_t;

    redir_t rd_d, rd_q;

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = pop_fire;
        if (pop_fire) begin
            rd_d.pc = head_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign redir_pc  = rd_q.pc;
    assign redir_vld = rd_q.vld;

endmodule

// File: rtl/pcc_unit_chk.sv
module pcc_unit_chk #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [PC_W-1:0]            fetch_pc,
    input logic                       pipe_adv,
    input logic                       irq_req,
    input logic                       jmp_restore,
    input logic                       jmp_chain,
    input logic [PC_W-1:0]            redir_pc,
    input logic                       redir_vld,
    input logic                       exc_flag,
    input logic [CNT_W-1:0]           pend,
    input logic [DEPTH-1:0][PC_W-1:0] entries
);

    a_r1_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (!exc_flag && !redir_vld && entries == '0));

    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_flag && pend == '0 && !irq_req && pipe_adv)
        |=> entries[DEPTH-1] == $past(fetch_pc));

    a_r3_take_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_flag && pend == '0 && irq_req) |=> exc_flag);

    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_flag && !jmp_restore) |=> (exc_flag && $stable(entries)));

    a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_flag && jmp_restore)
        |=> (!exc_flag && redir_vld && redir_pc == $past(entries[0])));

    a_r7_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |=> !exc_flag);

    a_r8_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_flag && pend == '0) |=> !redir_vld);

    a_r11_replay_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0 && !jmp_chain) |=> $stable(entries));

endmodule

bind pcc_unit pcc_unit_chk #(.PC_W(PC_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_pc   (fetch_pc),
    .pipe_adv   (pipe_adv),
    .irq_req    (irq_req),
    .jmp_restore(jmp_restore),
    .jmp_chain  (jmp_chain),
    .redir_pc   (redir_pc),
    .redir_vld  (redir_vld),
    .exc_flag   (exc_flag),
    .pend       (pend),
    .entries    (entries)
);

// File: tb/pcc_unit_test.sv
module pcc_unit_test;

    localparam int PC_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pipe_adv = 1'b0;
    logic            irq_req = 1'b0;
    logic            jmp_restore = 1'b0;
    logic            jmp_chain = 1'b0;
    logic [PC_W-1:0] redir_pc;
    logic            redir_vld;
    logic            exc_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pcc_unit #(.PC_W(PC_W), .DEPTH(3)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_pc   (fetch_pc),
        .pipe_adv   (pipe_adv),
        .irq_req    (irq_req),
        .jmp_restore(jmp_restore),
        .jmp_chain  (jmp_chain),
        .redir_pc   (redir_pc),
        .redir_vld  (redir_vld),
        .exc_flag   (exc_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock with the given strobes; outputs settle 1 ns after the edge
    task automatic cyc(input logic adv, input logic [PC_W-1:0] pc, input logic irq,
                       input logic rst, input logic chn);
        pipe_adv = adv; fetch_pc = pc; irq_req = irq;
        jmp_restore = rst; jmp_chain = chn;
        @(posedge clk); #1;
        pipe_adv = 1'b0; irq_req = 1'b0; jmp_restore = 1'b0; jmp_chain = 1'b0;
    endtask

    task automatic load3(input logic [PC_W-1:0] a, b, c);
        cyc(1, a, 0, 0, 0);
        cyc(1, b, 0, 0, 0);
        cyc(1, c, 0, 0, 0);
    endtask

    // full return sequence, checking each delivered PC
    task automatic replay(input string tag, input logic [PC_W-1:0] a, b, c);
        cyc(0, 0, 0, 1, 0);
        chk({tag, " R5 restore vld"}, redir_vld, 1);
        chk({tag, " R5 restore pc"}, redir_pc, a);
        chk({tag, " R5 exc cleared"}, exc_flag, 0);
        cyc(0, 0, 0, 0, 1);
        chk({tag, " R6 second pc"}, redir_pc, b);
        cyc(0, 0, 0, 0, 1);
        chk({tag, " R6 third pc"}, redir_pc, c);
        chk({tag, " R6 third vld"}, redir_vld, 1);
    endtask

    task automatic t_reset;
        chk("R1 exc after reset", exc_flag, 0);
        chk("R1 vld after reset", redir_vld, 0);
        cyc(0, 0, 1, 0, 0);
        chk("R3 exc set", exc_flag, 1);
        replay("R1 zero chain", 0, 0, 0);
    endtask

    task automatic t_basic;
        load3(16'h1000, 16'h1004, 16'h1008);
        chk("R2 no exc while live", exc_flag, 0);
        cyc(0, 0, 1, 0, 0);
        chk("R3 exc set", exc_flag, 1);
        chk("R3 no redirect on take", redir_vld, 0);
        cyc(1, 16'h2222, 0, 0, 0);
        chk("R3 exc held", exc_flag, 1);
        cyc(0, 0, 0, 1, 0);
        chk("R5 vld", redir_vld, 1);
        chk("R2 oldest first", redir_pc, 16'h1000);
        chk("R5 exc clear", exc_flag, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R5 single-cycle vld", redir_vld, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R6 second", redir_pc, 16'h1004);
        cyc(0, 0, 0, 0, 1);
        chk("R6 third", redir_pc, 16'h1008);
        cyc(0, 0, 0, 0, 1);
        chk("R8 stray chain jump", redir_vld, 0);
    endtask

    task automatic t_nested;
        load3(16'h0a00, 16'h0a10, 16'h0a20);
        cyc(0, 0, 1, 0, 0);
        cyc(1, 16'h5555, 1, 0, 0);
        chk("R4 exc stays", exc_flag, 1);
        chk("R4 no redirect", redir_vld, 0);
        cyc(0, 0, 1, 0, 1);
        chk("R4 chain jump while frozen ignored", redir_vld, 0);
        replay("R4 nested irq", 16'h0a00, 16'h0a10, 16'h0a20);
    endtask

    task automatic t_replay_irq;
        load3(16'h0b00, 16'h0b04, 16'h0b08);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R7 first pc", redir_pc, 16'h0b00);
        cyc(1, 16'h7777, 1, 0, 0);
        chk("R7 exc stays clear", exc_flag, 0);
        chk("R11 no redirect on adv", redir_vld, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R7 second pc intact", redir_pc, 16'h0b04);
        cyc(1, 16'h8888, 1, 0, 0);
        chk("R7 exc clear before last", exc_flag, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R11 third pc intact", redir_pc, 16'h0b08);
        chk("R7 exc clear at end", exc_flag, 0);
    endtask

    task automatic t_resume;
        load3(16'hffff, 16'h0c00, 16'h0c02);
        cyc(0, 0, 1, 0, 0);
        replay("R9 resume", 16'hffff, 16'h0c00, 16'h0c02);
    endtask

    task automatic t_simul;
        load3(16'h0d00, 16'h0d01, 16'h0d02);
        cyc(1, 16'h0dff, 1, 0, 0);
        chk("R10 irq wins", exc_flag, 1);
        replay("R10 no shift", 16'h0d00, 16'h0d01, 16'h0d02);
    endtask

    task automatic t_stray;
        load3(16'h0e00, 16'h0e01, 16'h0e02);
        cyc(0, 0, 0, 1, 0);
        chk("R8 restore while live vld", redir_vld, 0);
        chk("R8 restore while live exc", exc_flag, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R8 chain while live vld", redir_vld, 0);
        cyc(0, 0, 1, 0, 0);
        replay("R8 chain untouched", 16'h0e00, 16'h0e01, 16'h0e02);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_nested();
        t_replay_irq();
        t_resume();
        t_simul();
        t_stray();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule